// File: doc/BRIEF.md
# Three-Line 3x3 Convolution Engine

This block is a host-sequenced convolution accelerator for one output row at a time. The host tells the engine, one command at a time, which phase to enter next and how many 32-bit packets that phase moves. It then pushes an image row or a bank of filter weights, starts a compute pass, and pulls back the results. Each packet carries two 16-bit samples. The engine holds the three most recent image rows and sixteen 3x3 filters. A compute pass slides every filter across the three rows in one sweep, so all sixteen output channels are produced together.

All samples and weights are signed fixed point with 8 fraction bits (1 sign, 7 integer, 8 fraction). Border handling is left to the host. When it wants zero padding, it sends zero samples at the ends of each row, and those zeros count toward the row length. A one-cycle acknowledge closes every phase. A sticky error flag records any command or packet that arrives when the engine cannot take it.

Top module: `conv3_engine`

## Requirements
- R1: After reset, `ack`, `out_valid` and `err` are low, and all stored rows, weights and results are zero. A read issued straight after reset therefore returns zeros.
- R2: A command is taken only in the idle phase. Its `cmd_op` encoding is 0 load row, 1 load filters, 2 compute, 3 read results. `cmd_count` gives the packet count of a load or read phase and is ignored for compute.
- R3: A packet carries the lower-indexed sample in bits 15:0 and the next one in bits 31:16. Packet k of a phase covers elements 2k and 2k+1 of that phase's sequence.
- R4: A load-row command first moves the rows up by one, dropping the oldest. The following packets then fill the newest row from position 0. `ack` pulses in the cycle after the edge that takes the last commanded packet.
- R5: A filter load covers a flat weight sequence with index f*9 + r*3 + c. Here f is the filter, r is the row (0 = oldest) and c is the column.
- R6: A compute pass sets result (f, p) = sum over r, c of w[f][r][c] * row_r[p+c], for p = 0 .. LINE_LEN-3. The pass takes LINE_LEN-2 cycles after the command and then pulses `ack`. Stored results change only during a pass.
- R7: Each sum of full-precision products, which carry 16 fraction bits, is rounded by adding 128 and shifting right arithmetically by 8. It is then saturated to the range 0x8000 .. 0x7FFF.
- R8: A read of n packets gives one packet per cycle on `out_valid`/`out_data`, starting the second cycle after the command. The stream has no gaps. Packet j holds results 2j and 2j+1 of the flat order f*(LINE_LEN-2) + p. `ack` is high together with the last packet.
- R9: A command outside the idle phase, or a packet outside a load phase, is ignored and sets `err`. `err` stays high until reset.
- R10: Filter weights persist across row loads, so a new compute can run on a shifted window without reloading weights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Next phase: 0 row, 1 filters, 2 compute, 3 read |
| cmd_count | input | CNT_W | Packets in the commanded phase |
| pkt_valid | input | 1 | Input packet strobe |
| pkt_data | input | 32 | Two samples; lower index in bits 15:0 |
| out_valid | output | 1 | Result packet strobe |
| out_data | output | 32 | Two results; lower index in bits 15:0 |
| ack | output | 1 | One-cycle end-of-phase pulse |
| err | output | 1 | Sticky protocol error flag |

## Verification
The embedded assertions watch several rules on every cycle. They check that the error flag never clears and that a command arriving while busy always raises it. They check that the row shift moves the middle row into the oldest slot, that weights and results hold still outside their own load or compute phases, and that a read stream has no gaps before its acknowledge. Arithmetic cannot be seen by those properties: the window placement, the tap ordering, rounding of positive and negative halves, and saturation at both rails. The bench shows these against its own reference model. Its scenarios also cover the packet-order and result-order encodings, a shifted window with reused weights, a partial read, and stray commands and packets having no effect on the results.

// File: rtl/conv3_pkg.sv
// conv3_pkg: shared phase encoding, opcodes and the fixed-point rounding rule.
// Assumes 16-bit samples and weights with 8 fraction bits.
package conv3_pkg;
    localparam int SAMPLE_W = 16;
    localparam int FRAC_W   = 8;
    localparam int ACC_W    = 36;

    localparam logic [1:0] OP_LINE = 2'd0;
    localparam logic [1:0] OP_FILT = 2'd1;
    localparam logic [1:0] OP_COMP = 2'd2;
    localparam logic [1:0] OP_READ = 2'd3;

    typedef enum logic [2:0] {
        PH_IDLE, PH_LINE, PH_FILT, PH_COMP, PH_READ
    } phase_t;

    // Round a 16-fraction-bit sum to 8 fraction bits, half up, then clamp.
    function automatic logic [SAMPLE_W-1:0] round_sat(input logic signed [ACC_W-1:0] acc);
        logic signed [ACC_W-1:0] r;
        r = (acc + ACC_W'(1 <<< (FRAC_W - 1))) >>> FRAC_W;
        if (r > ACC_W'(32767))
            return 16'h7fff;
        else if (r < -ACC_W'(32768))
            return 16'h8000;
        return r[SAMPLE_W-1:0];
    endfunction
endpackage

// File: rtl/conv3_ctrl.sv
// conv3_ctrl: command decoder and phase sequencer.
// Takes commands only when idle, counts packets per phase, steps the window
// position during compute, and pulses ack at each phase end.
// Assumes the host waits for ack before issuing the next command.
module conv3_ctrl
    import conv3_pkg::*;
#(
    parameter int LINE_LEN = 8,
    parameter int CNT_W    = 8,
    localparam int NPOS    = LINE_LEN - 2,
    localparam int POS_W   = $clog2(NPOS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [CNT_W-1:0] cmd_count,
    input  logic             pkt_valid,
    output logic             line_shift,
    output logic             line_wr,
    output logic             filt_wr,
    output logic [CNT_W-1:0] idx,
    output logic             comp_wr,
    output logic [POS_W-1:0] pos,
    output logic             rd_fire,
    output logic             ack,
    output logic             err
);
    phase_t           phase;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] target;
    logic [CNT_W-1:0] cnt_nxt;
    logic             idle_cmd;

    assign cnt_nxt    = cnt + 1'b1;
    assign idle_cmd   = cmd_valid && (phase == PH_IDLE);
    assign line_shift = idle_cmd && (cmd_op == OP_LINE);
    assign line_wr    = (phase == PH_LINE) && pkt_valid;
    assign filt_wr    = (phase == PH_FILT) && pkt_valid;
    assign comp_wr    = (phase == PH_COMP);
    assign rd_fire    = (phase == PH_READ);
    assign idx        = cnt;

    // Phase sequencing, packet counting and end-of-phase acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            target <= '0;
            pos    <= '0;
            ack    <= 1'b0;
        end else begin
            ack <= 1'b0;
            unique case (phase)
                PH_IDLE: if (cmd_valid) begin
                    cnt    <= '0;
                    target <= cmd_count;
                    pos    <= '0;
                    unique case (cmd_op)
                        OP_COMP: phase <= PH_COMP;
                        default: begin
                            if (cmd_count == '0)
                                ack <= 1'b1;
                            else if (cmd_op == OP_LINE)
                                phase <= PH_LINE;
                            else if (cmd_op == OP_FILT)
                                phase <= PH_FILT;
                            else
                                phase <= PH_READ;
                        end
                    endcase
                end
                PH_LINE, PH_FILT: if (pkt_valid) begin
                    cnt <= cnt_nxt;
                    if (cnt_nxt == target) begin
                        phase <= PH_IDLE;
                        ack   <= 1'b1;
                    end
                end
                PH_COMP: begin
                    pos <= pos + 1'b1;
                    if (pos == POS_W'(NPOS - 1)) begin
                        phase <= PH_IDLE;
                        ack   <= 1'b1;
                    end
                end
                PH_READ: begin
                    cnt <= cnt_nxt;
                    if (cnt_nxt == target) begin
                        phase <= PH_IDLE;
                        ack   <= 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Sticky flag for commands or packets that arrive when they cannot be taken.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else if ((cmd_valid && phase != PH_IDLE) ||
                 (pkt_valid && phase != PH_LINE && phase != PH_FILT))
            err <= 1'b1;
    end

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R9
    busy_cmd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && phase != PH_IDLE) |=> err);
endmodule

// File: rtl/conv3_lines.sv
// conv3_lines: three row registers forming the vertical extent of the window.
// A shift drops the oldest row; packets then fill the newest row two samples
// at a time. Assumes LINE_LEN is even.
module conv3_lines #(
    parameter int LINE_LEN = 8,
    parameter int CNT_W    = 8,
    localparam int HALF    = LINE_LEN / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    output logic [15:0]      rows [3][LINE_LEN]
);
    // Row shift on a new load command, then packet writes into the newest row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < 3; r++)
                for (int c = 0; c < LINE_LEN; c++)
                    rows[r][c] <= '0;
        end else if (shift) begin
            rows[0] <= rows[1];
            rows[1] <= rows[2];
        end else if (wr) begin
            for (int k = 0; k < HALF; k++)
                if (wr_idx == CNT_W'(k)) begin
                    rows[2][2*k]   <= wr_data[15:0];
                    rows[2][2*k+1] <= wr_data[31:16];
                end
        end
    end

    // R4
    row_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> (rows[0][0] == $past(rows[1][0]) && rows[1][LINE_LEN-1] == $past(rows[2][LINE_LEN-1])));
endmodule

// File: rtl/conv3_filter.sv
// conv3_filter: one filter's nine weights and its 3x3 multiply-accumulate.
// Weights come from the flat filter stream at index FILT_IDX*9 + tap.
// The window sum is combinational on the current position.
module conv3_filter
    import conv3_pkg::*;
#(
    parameter int FILT_IDX = 0,
    parameter int LINE_LEN = 8,
    parameter int CNT_W    = 8,
    localparam int NPOS    = LINE_LEN - 2,
    localparam int POS_W   = $clog2(NPOS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic [15:0]      rows [3][LINE_LEN],
    input  logic [POS_W-1:0] pos,
    output logic [15:0]      result
);
    logic [8:0][15:0]        w;
    logic signed [ACC_W-1:0] acc;

    // Capture this filter's taps from the packets that carry them.
    always_ff @(posedge clk) begin
        if (!rst_n)
            w <= '0;
        else if (wr) begin
            for (int t = 0; t < 9; t++)
                if (wr_idx == CNT_W'((FILT_IDX*9 + t) / 2))
                    w[t] <= ((FILT_IDX*9 + t) % 2 == 1) ? wr_data[31:16] : wr_data[15:0];
        end
    end

    // Nine-tap signed dot product over the window at the current position.
    always_comb begin
        acc = '0;
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 3; c++) begin
                int col;
                col = int'(pos) + c;
                if (col > LINE_LEN - 1)
                    col = LINE_LEN - 1;
                acc = acc + ACC_W'($signed(w[r*3+c]) * $signed(rows[r][col]));
            end
    end

    assign result = round_sat(acc);

    // R10
    weight_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(w));
endmodule

// File: rtl/conv3_engine.sv
// conv3_engine: top of the three-line convolution engine.
// Ties the sequencer, the row registers and sixteen filter MACs together.
// Keeps the result bank and streams it out two results per packet.
// Assumes LINE_LEN is even, so the number of results is even.
module conv3_engine #(
    parameter int LINE_LEN = 8,
    parameter int NUM_FILT = 16,
    parameter int CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [CNT_W-1:0] cmd_count,
    input  logic             pkt_valid,
    input  logic [31:0]      pkt_data,
    output logic             out_valid,
    output logic [31:0]      out_data,
    output logic             ack,
    output logic             err
);
    localparam int NPOS  = LINE_LEN - 2;
    localparam int POS_W = $clog2(NPOS + 1);
    localparam int NRES  = NUM_FILT * NPOS;

    logic                      line_shift, line_wr, filt_wr, comp_wr, rd_fire;
    logic [CNT_W-1:0]          idx;
    logic [POS_W-1:0]          pos;
    logic [15:0]               rows [3][LINE_LEN];
    logic [NUM_FILT-1:0][15:0] mac_out;
    logic [NRES-1:0][15:0]     res;

    conv3_ctrl #(.LINE_LEN(LINE_LEN), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_count(cmd_count), .pkt_valid(pkt_valid), .line_shift(line_shift),
        .line_wr(line_wr), .filt_wr(filt_wr), .idx(idx), .comp_wr(comp_wr),
        .pos(pos), .rd_fire(rd_fire), .ack(ack), .err(err)
    );

    conv3_lines #(.LINE_LEN(LINE_LEN), .CNT_W(CNT_W)) u_lines (
        .clk(clk), .rst_n(rst_n), .shift(line_shift), .wr(line_wr),
        .wr_idx(idx), .wr_data(pkt_data), .rows(rows)
    );

    for (genvar f = 0; f < NUM_FILT; f++) begin : g_filt
        conv3_filter #(.FILT_IDX(f), .LINE_LEN(LINE_LEN), .CNT_W(CNT_W)) u_filt (
            .clk(clk), .rst_n(rst_n), .wr(filt_wr), .wr_idx(idx),
            .wr_data(pkt_data), .rows(rows), .pos(pos), .result(mac_out[f])
        );
    end

    // Store each filter's result for the current position during a pass.
    always_ff @(posedge clk) begin
        if (!rst_n)
            res <= '0;
        else if (comp_wr) begin
            for (int f = 0; f < NUM_FILT; f++)
                for (int p = 0; p < NPOS; p++)
                    if (pos == POS_W'(p))
                        res[f*NPOS + p] <= mac_out[f];
        end
    end

    // Present one result packet per read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= rd_fire;
            out_data  <= '0;
            if (rd_fire)
                for (int j = 0; j < NRES / 2; j++)
                    if (idx == CNT_W'(j))
                        out_data <= {res[2*j+1], res[2*j]};
        end
    end

    // R6
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !comp_wr |=> $stable(res));

    // R8
    read_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !ack) |=> out_valid);
endmodule

// File: tb/conv3_engine_bench.sv
module conv3_engine_bench;
    localparam int CLK_P = 10;
    localparam int L     = 8;
    localparam int NF    = 16;
    localparam int NP    = L - 2;
    localparam int NRES  = NF * NP;
    localparam int RPK   = NRES / 2;
    localparam int FPK   = NF * 9 / 2;
    // table: row seed, filter seed, row scale
    localparam int TBL[4][3] = '{'{1, 2, 64}, '{5, 7, 32}, '{9, 3, 128}, '{13, 11, 16}};

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cmd_valid = 0;
    logic [1:0]  cmd_op = 0;
    logic [7:0]  cmd_count = 0;
    logic        pkt_valid = 0;
    logic [31:0] pkt_data = 0;
    logic        out_valid, ack, err;
    logic [31:0] out_data;

    int n_chk = 0;
    int n_err = 0;
    int bl[3][L];
    int bw[NF*9];
    logic [31:0] rx[RPK];
    int rx_n;
    bit rx_ack_last;

    always #(CLK_P/2) clk = ~clk;

    conv3_engine #(.LINE_LEN(L), .NUM_FILT(NF), .CNT_W(8)) u_conv3_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_count(cmd_count), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
        .out_valid(out_valid), .out_data(out_data), .ack(ack), .err(err)
    );

    task automatic chk(input string req, input longint got, input longint exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int model(input int k);
        longint s = 0;
        longint r;
        int f = k / NP;
        int p = k % NP;
        for (int i = 0; i < 3; i++)
            for (int c = 0; c < 3; c++)
                s += longint'(bw[f*9 + i*3 + c]) * longint'(bl[i][p+c]);
        r = (s + 128) >>> 8;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < 3; i++) for (int c = 0; c < L; c++) bl[i][c] = 0;
        for (int i = 0; i < NF*9; i++) bw[i] = 0;
    endtask

    task automatic send_cmd(input logic [1:0] op, input int n);
        cmd_valid = 1; cmd_op = op; cmd_count = n[7:0];
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic send_pkt(input int a, input int b);
        pkt_valid = 1; pkt_data = {b[15:0], a[15:0]};
        @(negedge clk);
        pkt_valid = 0;
    endtask

    task automatic wait_ack(input string req);
        bit seen = 0;
        for (int i = 0; i < 200 && !seen; i++) begin
            if (ack) seen = 1;
            else @(negedge clk);
        end
        chk(req, seen, 1);
    endtask

    // R4: shift rows, newest gets v
    task automatic load_row(input int v[L]);
        for (int c = 0; c < L; c++) begin
            bl[0][c] = bl[1][c]; bl[1][c] = bl[2][c]; bl[2][c] = v[c];
        end
        send_cmd(2'd0, L/2);
        for (int k = 0; k < L/2; k++) send_pkt(v[2*k], v[2*k+1]);
        wait_ack("R4 row ack");
    endtask

    task automatic load_filters();
        send_cmd(2'd1, FPK);
        for (int k = 0; k < FPK; k++) send_pkt(bw[2*k], bw[2*k+1]);
        wait_ack("R5 filter ack");
    endtask

    task automatic compute();
        send_cmd(2'd2, 0);
        wait_ack("R6 compute ack");
    endtask

    task automatic read_pkts(input int n);
        rx_n = 0; rx_ack_last = 0;
        send_cmd(2'd3, n);
        for (int i = 0; i < n + 3; i++) begin
            @(negedge clk);
            if (out_valid && rx_n < RPK) begin
                rx[rx_n] = out_data;
                if (rx_n == n - 1) rx_ack_last = ack;
                rx_n++;
            end
        end
    endtask

    task automatic check_all(input string req);
        read_pkts(RPK);
        chk({req, " R8 packet count"}, rx_n, RPK);
        for (int j = 0; j < rx_n; j++) begin
            chk({req, " R6 R7 low"},  longint'($signed(rx[j][15:0])),  model(2*j));
            chk({req, " R6 R7 high"}, longint'($signed(rx[j][31:16])), model(2*j+1));
        end
    endtask

    task automatic fill_rows_const(input int v);
        int row[L];
        for (int c = 0; c < L; c++) row[c] = v;
        for (int i = 0; i < 3; i++) load_row(row);
    endtask

    initial begin : watchdog
        #(CLK_P * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        int row[L];
        do_reset();
        // R1 reset state
        chk("R1 ack", ack, 0);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 err", err, 0);
        read_pkts(RPK);
        for (int j = 0; j < RPK; j++) chk("R1 results zero", rx[j], 0);

        // Table scenarios: R2 R3 R5 R6 R7 R8
        for (int e = 0; e < 4; e++) begin
            for (int i = 0; i < 3; i++) begin
                for (int c = 0; c < L; c++)
                    row[c] = (((TBL[e][0] + i) * 7 + c * 5) % 41 - 20) * TBL[e][2];
                load_row(row);
            end
            for (int k = 0; k < NF*9; k++) bw[k] = ((TBL[e][1] * 3 + k * 5) % 17 - 8) * 16;
            load_filters();
            compute();
            check_all("table");
            chk("R9 no error on legal traffic", err, 0);
        end

        // R10 R4: shift in a new row, reuse weights
        for (int c = 0; c < L; c++) row[c] = (c * 11 % 13 - 6) * 100;
        load_row(row);
        compute();
        check_all("R10 shifted window");

        // R7 rounding: 1/256 times 0.5 over nine taps -> 5; negative -> -4
        for (int k = 0; k < NF*9; k++) bw[k] = 16'h0080;
        load_filters();
        fill_rows_const(1);
        compute();
        read_pkts(1);
        chk("R7 round positive", longint'($signed(rx[0][15:0])), 5);
        fill_rows_const(-1);
        compute();
        read_pkts(1);
        chk("R7 round negative", longint'($signed(rx[0][15:0])), -4);

        // R7 saturation at both rails
        for (int k = 0; k < NF*9; k++) bw[k] = 32512;
        load_filters();
        fill_rows_const(32512);
        compute();
        read_pkts(1);
        chk("R7 saturate high", rx[0], 32'h7fff7fff);
        for (int k = 0; k < NF*9; k++) bw[k] = -32512;
        load_filters();
        compute();
        read_pkts(1);
        chk("R7 saturate low", rx[0], 32'h80008000);

        // R8 partial read: three packets, ack with the last
        read_pkts(3);
        chk("R8 partial count", rx_n, 3);
        chk("R8 ack with last packet", rx_ack_last, 1);

        // R9 packet while idle is ignored
        do_reset();
        for (int k = 0; k < NF*9; k++) bw[k] = 256;
        load_filters();
        send_pkt(1000, 2000);
        chk("R9 err after stray packet", err, 1);
        compute();
        check_all("R9 stray packet ignored");

        // R9 command during compute is ignored
        do_reset();
        for (int i = 0; i < 3; i++) begin
            for (int c = 0; c < L; c++) row[c] = (i * 3 + c) * 40 - 200;
            load_row(row);
        end
        for (int k = 0; k < NF*9; k++) bw[k] = (k % 7 - 3) * 20;
        load_filters();
        send_cmd(2'd2, 0);
        send_cmd(2'd0, L/2);
        chk("R9 err after busy command", err, 1);
        wait_ack("R9 compute still ends");
        check_all("R9 busy command ignored");
        chk("R9 err sticky", err, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule